// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block serialises one packet onto the D+ and D- lines of a low-speed USB link. It runs from a clock that is eight times the bit rate. A bit period lasts a parameterised number of clock ticks. The block makes the sync byte itself. It then fetches the remaining bytes one at a time through a read port into an external byte buffer. Bits leave LSB first. They are NRZI-encoded, and a stuffed bit is added after every run of six ones. The packet closes with a fixed end-of-packet sequence, after which the block lets go of the bus.

A second start input sends a short handshake: the sync byte followed by an ACK or NAK PID, with no buffer access. The block also keeps a pending device address that software may write at any time. That address is copied to the active address output only when a data packet finishes. A finished handshake never copies it. While a packet is on the wire, any further start request is ignored.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe, dp, dm, done and busy are 0, and dev_addr is 0.
- R2: In the cycle after an accepted start, dp=0, dm=1 (J), oe=0 and busy=1. One cycle later oe rises, and the line holds J for one full bit time before the first sync bit.
- R3: Every bit lasts TPB clock ticks. J is driven as dp=0, dm=1 and K as dp=1, dm=0. dp and dm are never both 1.
- R4: The first byte sent is the sync byte 0x80, and each byte goes out LSB first. byte_cnt (at least 1) counts the sync byte. Packet byte k (k ≥ 1) is read from buffer index k-1, which the block presents on rd_idx.
- R5: NRZI: a 0 bit toggles the line and a 1 bit holds it.
- R6: After six consecutive 1 bits a toggle (stuffed 0) is inserted and the run count restarts. This also applies after the final data bit.
- R7: End of packet is SE0 (dp=dm=0) for two bit times, then J for one bit time. In the next cycle oe=0, dp=dm=0, busy=0 and done is 1 for exactly one cycle.
- R8: hs_start sends exactly two bytes: sync, then PID 0xD2 (ACK) when hs_nak=0 or 0x5A (NAK) when hs_nak=1. If start and hs_start are both high, the handshake wins.
- R9: A start or hs_start while busy=1 is ignored; the packet in progress goes out unchanged.
- R10: addr_wr loads addr_in into a pending register. dev_addr takes the pending value only in the cycle done rises after a data packet. dev_addr is unchanged after a handshake, and at all other times.
- R11: If addr_wr is high on the clock edge that ends a data packet, dev_addr takes that cycle's addr_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, TPB ticks per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a data packet |
| hs_start | input | 1 | Request to send a handshake packet |
| hs_nak | input | 1 | Handshake PID select: 0 ACK, 1 NAK |
| byte_cnt | input | CW | Data packet length in bytes including sync (at least 1) |
| rd_idx | output | CW | Buffer index of the next byte to send |
| rd_byte | input | 8 | Buffer byte at rd_idx (combinational read) |
| addr_wr | input | 1 | Load strobe for the pending address |
| addr_in | input | AW | New device address |
| dp | output | 1 | D+ line value |
| dm | output | 1 | D- line value |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse when the bus is released |
| dev_addr | output | AW | Active device address |

## Verification
An address write and the address commit at the end of a packet can fall in the same cycle. The bench provokes this by raising addr_wr for exactly the one cycle whose closing edge releases the bus. It then checks that dev_addr shows the freshly written value after a data packet, and still shows the old value after a handshake. A start request can likewise arrive in the middle of a packet. The bench confirms that the line waveform, sampled mid-bit against a sequence rebuilt arithmetically with NRZI and stuffing, is unchanged.

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int TPB = 8,
  parameter int CW  = 5,
  parameter int AW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hs_start,
  input  logic          hs_nak,
  input  logic [CW-1:0] byte_cnt,
  output logic [CW-1:0] rd_idx,
  input  logic [7:0]    rd_byte,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_in,
  output logic          dp,
  output logic          dm,
  output logic          oe,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] dev_addr
);
  localparam int TW = $clog2(2 * TPB);
  localparam logic [7:0] SYNC    = 8'h80;
  localparam logic [7:0] PID_ACK = 8'hD2;
  localparam logic [7:0] PID_NAK = 8'h5A;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_LEAD, S_BITS, S_SE0, S_TAIL} st_t;

  st_t           st;
  logic [TW-1:0] tc;
  logic [7:0]    sh;
  logic [2:0]    bi;
  logic [2:0]    ones;
  logic [CW-1:0] bc, last;
  logic          lk, fin, hs, hk, done_q;
  logic [AW-1:0] pend, dev_q;

  wire           go    = (st == S_IDLE) && (start || hs_start);
  wire [TW-1:0]  lim   = (st == S_SE0) ? TW'(2 * TPB - 1) : TW'(TPB - 1);
  wire           tend  = (tc == lim);
  wire           stuff = (ones == 3'd6);
  wire [7:0]     nxt   = hs ? (hk ? PID_NAK : PID_ACK) : rd_byte;

  assign rd_idx   = bc;
  assign oe       = (st != S_IDLE) && (st != S_ARM);
  assign busy     = (st != S_IDLE);
  assign dp       = (st == S_BITS) && lk;
  assign dm       = (st == S_ARM) || (st == S_LEAD) || (st == S_TAIL) ||
                    ((st == S_BITS) && !lk);
  assign done     = done_q;
  assign dev_addr = dev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tc     <= '0;
      sh     <= '0;
      bi     <= '0;
      ones   <= '0;
      bc     <= '0;
      last   <= '0;
      lk     <= 1'b0;
      fin    <= 1'b0;
      hs     <= 1'b0;
      hk     <= 1'b0;
      done_q <= 1'b0;
      pend   <= '0;
      dev_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (addr_wr) pend <= addr_in;
      case (st)
        S_IDLE: if (go) begin
          st   <= S_ARM;
          hs   <= hs_start;
          hk   <= hs_nak;
          last <= hs_start ? CW'(1) : byte_cnt - CW'(1);
          sh   <= SYNC;
          bi   <= '0;
          bc   <= '0;
          ones <= '0;
          lk   <= 1'b0;
          fin  <= 1'b0;
          tc   <= '0;
        end
        S_ARM: begin
          st <= S_LEAD;
          tc <= '0;
        end
        S_LEAD, S_BITS: begin
          if (!tend) tc <= tc + 1'b1;
          else begin
            tc <= '0;
            if (stuff) begin
              lk   <= ~lk;
              ones <= '0;
              st   <= S_BITS;
            end else if (fin) begin
              st <= S_SE0;
            end else begin
              st <= S_BITS;
              if (!sh[0]) begin
                lk   <= ~lk;
                ones <= '0;
              end else begin
                ones <= ones + 3'd1;
              end
              sh <= sh >> 1;
              bi <= bi + 3'd1;
              if (bi == 3'd7) begin
                if (bc == last) fin <= 1'b1;
                else begin
                  bc <= bc + 1'b1;
                  sh <= nxt;
                end
              end
            end
          end
        end
        S_SE0: begin
          if (tend) begin
            st <= S_TAIL;
            tc <= '0;
          end else tc <= tc + 1'b1;
        end
        S_TAIL: begin
          if (tend) begin
            st     <= S_IDLE;
            tc     <= '0;
            done_q <= 1'b1;
            if (!hs) dev_q <= addr_wr ? addr_in : pend;
          end else tc <= tc + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe,
  input logic          dp,
  input logic          dm,
  input logic          done,
  input logic [AW-1:0] dev_addr
);
  p_j_before_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dm) && !$past(dp)));

  p_never_both_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm));

  p_release_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!oe && !dp && !dm));

  p_j_after_se0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && $past(!dp && !dm) && (dp || dm)) |-> (dm && !dp));

  p_addr_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> done);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe(oe), .dp(dp), .dm(dm),
  .done(done), .dev_addr(dev_addr)
);

// File: tb/sim_usb_ls_tx.sv
module sim_usb_ls_tx;
  localparam int TPB = 8;
  localparam int CW  = 5;
  localparam int AW  = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, hs_start, hs_nak, addr_wr, dp, dm, oe, busy, done;
  logic [CW-1:0] byte_cnt, rd_idx;
  logic [7:0]    rd_byte;
  logic [AW-1:0] addr_in, dev_addr;
  logic [7:0]    mem [0:31];

  assign rd_byte = mem[rd_idx];

  usb_ls_tx #(.TPB(TPB), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_start(hs_start), .hs_nak(hs_nak),
    .byte_cnt(byte_cnt), .rd_idx(rd_idx), .rd_byte(rd_byte), .addr_wr(addr_wr),
    .addr_in(addr_in), .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done),
    .dev_addr(dev_addr)
  );

  int total = 0, bad = 0;
  int exp_sym [0:1023];
  int nsym;
  int exp_addr = 0, pend_addr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // symbol codes follow {dp,dm}: J=1, K=2, SE0=0
  task automatic build(input bit hsm, input bit nak, input int cnt);
    int lvl, ones, nb;
    logic [7:0] v;
    nsym = 0; lvl = 1; ones = 0;
    exp_sym[nsym++] = 1;
    nb = hsm ? 2 : cnt;
    for (int b = 0; b < nb; b++) begin
      v = (b == 0) ? 8'h80 : (hsm ? (nak ? 8'h5A : 8'hD2) : mem[b-1]);
      for (int i = 0; i < 8; i++) begin
        if (!v[i]) begin lvl = 3 - lvl; ones = 0; end
        else ones++;
        exp_sym[nsym++] = lvl;
        if (ones == 6) begin lvl = 3 - lvl; ones = 0; exp_sym[nsym++] = lvl; end
      end
    end
    exp_sym[nsym++] = 0;
    exp_sym[nsym++] = 0;
    exp_sym[nsym++] = 1;
  endtask

  task automatic run(input bit hsm, input bit nak, input int cnt, input bit both,
                     input bit intrude, input bit late, input int lateval, input string req);
    build(hsm, nak, cnt);
    start    = !hsm || both;
    hs_start = hsm;
    hs_nak   = nak;
    byte_cnt = CW'(cnt);
    @(negedge clk);
    start = 0; hs_start = 0;
    chk({dp, dm} == 2'b01 && !oe && busy, "R2", "arm line/oe/busy",
        {29'd0, dp, dm, oe}, 3'b010);
    @(negedge clk);
    chk(oe, "R2", "oe after arm", oe, 1);
    repeat (TPB/2) @(negedge clk);
    for (int k = 0; k < nsym; k++) begin
      chk(int'({dp, dm}) == exp_sym[k] && oe,
          (k == 0) ? "R2" : (exp_sym[k] == 0 || k == nsym-1) ? "R7" : req,
          $sformatf("symbol %0d", k), {dp, dm}, exp_sym[k]);
      if (k < nsym-1) begin
        if (intrude && k == 3) begin
          start = 1; hs_start = 1; byte_cnt = 3;
          @(negedge clk);
          start = 0; hs_start = 0;
          repeat (TPB-1) @(negedge clk);
        end else repeat (TPB) @(negedge clk);
      end
    end
    repeat (TPB - TPB/2 - 1) @(negedge clk);
    chk(!done && oe, "R7", "no early release", done, 0);
    if (late) begin addr_wr = 1; addr_in = AW'(lateval); pend_addr = lateval; end
    @(negedge clk);
    addr_wr = 0;
    if (!hsm) exp_addr = pend_addr;
    chk(done && !oe && !dp && !dm && !busy, "R7", "release pulse",
        {27'd0, done, oe, dp, dm, busy}, 5'b10000);
    chk(int'(dev_addr) == exp_addr, late ? "R11" : "R10", "dev_addr at release",
        dev_addr, exp_addr);
    @(negedge clk);
    chk(!done, "R7", "done single cycle", done, 0);
  endtask

  task automatic wr_addr(input int a);
    addr_wr = 1; addr_in = AW'(a); pend_addr = a;
    @(negedge clk);
    addr_wr = 0;
    chk(int'(dev_addr) == exp_addr, "R10", "no commit on write", dev_addr, exp_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; hs_start = 0; hs_nak = 0; addr_wr = 0; addr_in = '0; byte_cnt = '0;
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!oe && !dp && !dm && !done && !busy && dev_addr == 0, "R1", "reset outputs",
        {27'd0, oe, dp, dm, done, busy}, 0);

    // handshakes (R8), address held back after handshake (R10)
    wr_addr(5);
    run(1, 0, 0, 0, 0, 0, 0, "R8");
    run(1, 1, 0, 0, 0, 0, 0, "R8");
    run(1, 0, 0, 1, 0, 0, 0, "R8");
    chk(dev_addr == 0, "R10", "handshake keeps address", dev_addr, 0);

    // sync only data packet commits pending address (R4 R10)
    run(0, 0, 1, 0, 0, 0, 0, "R4");

    // long ones runs (R6), zeros (R5)
    for (int i = 0; i < 4; i++) mem[i] = 8'hFF;
    run(0, 0, 5, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) mem[i] = 8'h00;
    run(0, 0, 4, 0, 0, 0, 0, "R5");
    mem[0] = 8'hF0; mem[1] = 8'h03; mem[2] = 8'hFC; mem[3] = 8'h7E;
    run(0, 0, 5, 0, 0, 0, 0, "R6");

    // sweep of lengths and byte patterns
    for (int n = 1; n <= 12; n++) begin
      for (int i = 0; i < n; i++) mem[i] = 8'((n * 37 + i * 91 + 13) ^ (i << n % 5));
      wr_addr(n + 10);
      run(0, 0, n, 0, 0, 0, 0, "R4 R5 R6");
    end

    // start requests during a packet are ignored (R9)
    for (int i = 0; i < 6; i++) mem[i] = 8'(i * 53 + 1);
    run(0, 0, 7, 0, 1, 0, 0, "R9");

    // address write colliding with commit (R11)
    run(0, 0, 3, 0, 0, 1, 99, "R4");
    run(1, 1, 0, 0, 0, 1, 42, "R8");
    chk(dev_addr == 99, "R11", "handshake collision keeps active", dev_addr, 99);
    run(0, 0, 1, 0, 0, 0, 0, "R4");
    chk(dev_addr == 42, "R11", "pending from collision committed", dev_addr, 42);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule